// File: doc/BRIEF.md
# Double-Buffered Tiled LED Column Latch Array

This block is the screen-side storage of a row-scanned monochrome LED wall built from identical tiles. A host writes 16-bit words over a simple parallel bus. Each word fills one byte-wide column latch in two tiles that sit one above the other. The low byte goes to the even tile of a vertical pair and the high byte goes to the odd tile of the same pair. The horizontal tile is chosen from the upper address bits. The latch inside the tile is chosen from the lower address bits. The vertical pair comes from a separate level-select input and not from the address.

Every column latch has two stages. Writes only reach the first, hidden stage. One transfer strobe copies every hidden byte into its visible stage in the same clock edge. The same strobe also loads the 4-bit row code that drives the one-hot row lines. The host can therefore stream the data for the next row while the current row stays lit, and then switch data and row together.

Horizontal selection travels along each tile chain as a set of 16 strobe lines. Each tile passes the lines on shifted down by one position and acts on line 0 only. This is why all tiles are identical.

Top module: `lcl_led_latch_array`

## Requirements
- R1: While `rst` is high at a clock edge, all hidden and visible latches are cleared. After reset, `col_out` is all zero and `row_drive` is 16'h0001.
- R2: A write is a clock edge with `bus_wr` high. Let h = `bus_addr[8:5]`, k = `bus_addr[4:1]` and p = `vlevel_sel`, with h < H_MODS and p < V_PAIRS. The write stores `bus_data[7:0]` in hidden latch k of tile (v=2p, h) and `bus_data[15:8]` in hidden latch k of tile (v=2p+1, h). No other latch changes. Visible byte k of tile (v,h) appears at `col_out[((v*H_MODS+h)*16+k)*8 +: 8]`.
- R3: `col_out` changes only after a clock edge with `xfer_stb` high. Writes alone never alter it.
- R4: A transfer edge copies every hidden latch to its visible latch at once. The hidden contents are kept, so a repeated transfer shows the same data again.
- R5: When a write and a transfer fall on the same edge, the transfer shows the hidden contents from before that edge. The written byte becomes visible at the next transfer.
- R6: A write with h >= H_MODS or with p >= V_PAIRS changes no latch.
- R7: An edge with `bus_wr` low changes no hidden latch, whatever the values of address, data and level select.
- R8: At a transfer edge, `row_drive` becomes 1 << `row_code`. It holds that value between transfers, and exactly one bit of it is set at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_addr | input | 8 | Word address bits [8:1]: [8:5] horizontal tile, [4:1] latch |
| bus_data | input | 16 | Write data: low byte to even tile, high byte to odd tile |
| vlevel_sel | input | 3 | Vertical pair select |
| xfer_stb | input | 1 | Copy all hidden latches to visible and load row code |
| row_code | input | 4 | Row to drive after the next transfer |
| col_out | output | V_PAIRS*2*H_MODS*128 | Visible column bytes of all tiles |
| row_drive | output | 16 | One-hot row drive |

## Verification
A write and a transfer can land on the same clock edge. In that case the visible stage must take the hidden bytes from before the write, and the new byte must wait for the following transfer. The bench provokes this with a directed same-edge write/transfer followed by a second transfer. Random traffic also asserts `bus_wr` and `xfer_stb` together often. A bench model applies the transfer before the write in each step, and every visible byte and the row vector are compared against that model after each edge.

// File: rtl/lcl_pkg.sv
package lcl_pkg;
    // Fixed geometry of one tile; the address decode depends on these.
    localparam int LATCHES    = 16;  // first-level latches per tile
    localparam int BYTE_W     = 8;   // bits per column latch
    localparam int ROWS       = 16;  // scan rows shared by both halves
    localparam int LINES      = 16;  // horizontal strobe lines in a chain
    localparam int TILE_BITS  = LATCHES * BYTE_W;

    typedef logic [BYTE_W-1:0]     col_byte_t;
    typedef logic [3:0]            lat_sel_t;
    typedef logic [LINES-1:0]      strobe_lines_t;
    typedef logic [3:0]            row_code_t;
    typedef logic [ROWS-1:0]       row_vec_t;
endpackage

// File: rtl/lcl_bus_decode.sv
module lcl_bus_decode
    import lcl_pkg::*;
#(
    parameter int H_MODS  = 2,
    parameter int V_PAIRS = 2
) (
    input  logic                      bus_wr,
    input  logic [8:1]                bus_addr,
    input  logic [2:0]                vlevel_sel,
    output strobe_lines_t             pair_lines [V_PAIRS],
    output lat_sel_t                  lat_sel
);
    logic [3:0] hpos;

    assign hpos    = bus_addr[8:5];
    assign lat_sel = bus_addr[4:1];

    // One strobe line per horizontal position, raised only in the chain
    // belonging to the addressed vertical pair.
    always_comb begin
        for (int p = 0; p < V_PAIRS; p++) begin
            pair_lines[p] = '0;
            if (bus_wr && (int'(vlevel_sel) == p)) begin
                for (int h = 0; h < H_MODS; h++) begin
                    if (int'(hpos) == h) begin
                        pair_lines[p][h] = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/lcl_tile.sv
module lcl_tile
    import lcl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  strobe_lines_t        en_in,
    input  lat_sel_t             lat_sel,
    input  col_byte_t            wr_byte,
    input  logic                 xfer,
    output strobe_lines_t        en_out,
    output logic [TILE_BITS-1:0] disp
);
    col_byte_t            stage1 [LATCHES];
    col_byte_t            stage2 [LATCHES];
    logic [TILE_BITS-1:0] stage1_flat;

    // The next tile sees the lines moved down one place, so its line 0
    // is this tile's line 1.
    assign en_out = {1'b0, en_in[LINES-1:1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < LATCHES; k++) begin
                stage1[k] <= '0;
                stage2[k] <= '0;
            end
        end else begin
            if (xfer) begin
                for (int k = 0; k < LATCHES; k++) begin
                    stage2[k] <= stage1[k];
                end
            end
            if (en_in[0]) begin
                stage1[lat_sel] <= wr_byte;
            end
        end
    end

    always_comb begin
        for (int k = 0; k < LATCHES; k++) begin
            disp[k*BYTE_W +: BYTE_W]        = stage2[k];
            stage1_flat[k*BYTE_W +: BYTE_W] = stage1[k];
        end
    end

    // R3: visible data holds without a transfer
    a_r3_disp_hold: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(disp));

    // R4, R5: a transfer shows the hidden contents from before the edge
    a_r4_copy_all: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (disp == $past(stage1_flat)));

    // R7: hidden latches keep their values when this tile is not strobed
    a_r7_hidden_hold: assert property (@(posedge clk) disable iff (rst)
        !en_in[0] |=> $stable(stage1_flat));
endmodule

// File: rtl/lcl_row_drive.sv
module lcl_row_drive
    import lcl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      xfer,
    input  row_code_t row_code,
    output row_vec_t  row_drive
);
    row_code_t cur_row;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_row <= '0;
        end else if (xfer) begin
            cur_row <= row_code;
        end
    end

    always_comb begin
        row_drive = '0;
        row_drive[cur_row] = 1'b1;
    end

    // R8: exactly one row line is active
    a_r8_one_row: assert property (@(posedge clk) disable iff (rst)
        $countones(row_drive) == 1);

    // R8: row lines move only on a transfer
    a_r8_row_hold: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(row_drive));

    // R8: a transfer drives the requested row
    a_r8_row_load: assert property (@(posedge clk) disable iff (rst)
        xfer |=> (row_drive == (row_vec_t'(1) << $past(row_code))));
endmodule

// File: rtl/lcl_led_latch_array.sv
module lcl_led_latch_array
    import lcl_pkg::*;
#(
    parameter int H_MODS  = 2,   // tiles per horizontal chain, at most 16
    parameter int V_PAIRS = 2,   // vertical tile pairs, at most 8
    localparam int V_MODS = 2 * V_PAIRS,
    localparam int TILES  = V_MODS * H_MODS,
    localparam int COL_W  = TILES * TILE_BITS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic [8:1]       bus_addr,
    input  logic [15:0]      bus_data,
    input  logic [2:0]       vlevel_sel,
    input  logic             xfer_stb,
    input  logic [3:0]       row_code,
    output logic [COL_W-1:0] col_out,
    output logic [15:0]      row_drive
);
    strobe_lines_t pair_lines [V_PAIRS];
    lat_sel_t      lat_sel;
    strobe_lines_t chain [V_MODS][H_MODS+1];

    lcl_bus_decode #(
        .H_MODS  (H_MODS),
        .V_PAIRS (V_PAIRS)
    ) u_decode (
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .vlevel_sel (vlevel_sel),
        .pair_lines (pair_lines),
        .lat_sel    (lat_sel)
    );

    for (genvar v = 0; v < V_MODS; v++) begin : g_vert
        col_byte_t lane_byte;

        // Even tile of a pair takes the low byte, odd tile the high byte.
        if ((v % 2) == 0) begin : g_lo
            assign lane_byte = bus_data[7:0];
        end else begin : g_hi
            assign lane_byte = bus_data[15:8];
        end

        assign chain[v][0] = pair_lines[v/2];

        for (genvar h = 0; h < H_MODS; h++) begin : g_horz
            lcl_tile u_tile (
                .clk     (clk),
                .rst     (rst),
                .en_in   (chain[v][h]),
                .lat_sel (lat_sel),
                .wr_byte (lane_byte),
                .xfer    (xfer_stb),
                .en_out  (chain[v][h+1]),
                .disp    (col_out[(v*H_MODS+h)*TILE_BITS +: TILE_BITS])
            );
        end

        // R6: no strobe line is left over once it has passed the last tile
        a_r6_chain_drained: assert property (@(posedge clk) disable iff (rst)
            chain[v][H_MODS] == '0);

        // R2: a write strobes at most one tile in each chain
        a_r2_one_tile: assert property (@(posedge clk) disable iff (rst)
            $onehot0(chain[v][0]));
    end

    lcl_row_drive u_rows (
        .clk       (clk),
        .rst       (rst),
        .xfer      (xfer_stb),
        .row_code  (row_code),
        .row_drive (row_drive)
    );
endmodule

// File: tb/lcl_led_latch_array_bench.sv
`timescale 1ns/1ps
module lcl_led_latch_array_bench;
    localparam int H  = 2;
    localparam int VP = 2;
    localparam int VM = 2 * VP;
    localparam int CW = VM * H * 128;

    logic          clk = 1'b0;
    logic          rst;
    logic          bus_wr;
    logic [8:1]    bus_addr;
    logic [15:0]   bus_data;
    logic [2:0]    vlevel_sel;
    logic          xfer_stb;
    logic [3:0]    row_code;
    logic [CW-1:0] col_out;
    logic [15:0]   row_drive;

    logic [7:0]    m1 [VM][H][16];
    logic [CW-1:0] exp_col;
    logic [15:0]   exp_row;
    int            total = 0;
    int            bad = 0;
    bit            done = 1'b0;

    always #4 clk = ~clk;

    lcl_led_latch_array #(.H_MODS(H), .V_PAIRS(VP)) u_lcl_led_latch_array (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_data(bus_data), .vlevel_sel(vlevel_sel), .xfer_stb(xfer_stb),
        .row_code(row_code), .col_out(col_out), .row_drive(row_drive)
    );

    function automatic logic [CW-1:0] pack_hidden();
        logic [CW-1:0] r;
        r = '0;
        for (int v = 0; v < VM; v++)
            for (int h = 0; h < H; h++)
                for (int k = 0; k < 16; k++)
                    r[((v*H+h)*16+k)*8 +: 8] = m1[v][h][k];
        return r;
    endfunction

    task automatic model_clear();
        for (int v = 0; v < VM; v++)
            for (int h = 0; h < H; h++)
                for (int k = 0; k < 16; k++)
                    m1[v][h][k] = 8'h00;
        exp_col = '0;
        exp_row = 16'h0001;
    endtask

    task automatic check_all(string tag);
        total++;
        if (col_out !== exp_col) begin
            bad++;
            $display("FAIL %s col_out actual=%h expected=%h", tag, col_out, exp_col);
        end
        total++;
        if (row_drive !== exp_row) begin
            bad++;
            $display("FAIL %s row_drive actual=%h expected=%h", tag, row_drive, exp_row);
        end
    endtask

    // Drive at a falling edge, update the model (transfer first, then write),
    // then sample at the next falling edge.
    task automatic step(logic wr, logic [8:1] addr, logic [15:0] data,
                        logic [2:0] vs, logic xf, logic [3:0] rc, string tag);
        int h, k, p;
        bus_wr = wr; bus_addr = addr; bus_data = data;
        vlevel_sel = vs; xfer_stb = xf; row_code = rc;
        h = int'(addr[8:5]); k = int'(addr[4:1]); p = int'(vs);
        if (xf) begin
            exp_col = pack_hidden();
            exp_row = 16'(1) << rc;
        end
        if (wr && h < H && p < VP) begin
            m1[2*p][h][k]   = data[7:0];
            m1[2*p+1][h][k] = data[15:8];
        end
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0; xfer_stb = 1'b0;
        check_all(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5EED_1A7C));
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_data = '0;
        vlevel_sel = '0; xfer_stb = 1'b0; row_code = '0;
        model_clear();
        repeat (3) @(posedge clk);
        // writes during reset must be discarded (R1)
        bus_wr = 1'b1; bus_data = 16'hFFFF; xfer_stb = 1'b1; row_code = 4'd9;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0; bus_wr = 1'b0; xfer_stb = 1'b0;
        check_all("R1");
        step(1'b0, '0, '0, '0, 1'b1, 4'd0, "R1");

        // R2: write with no transfer leaves output unchanged (R3)
        step(1'b1, {4'd1, 4'd3}, 16'hA55A, 3'd1, 1'b0, 4'd0, "R3");
        // transfer makes it visible; row 5 (R2, R8)
        step(1'b0, '0, '0, '0, 1'b1, 4'd5, "R2");
        // boundary: last tile, last latch
        step(1'b1, {4'(H-1), 4'd15}, 16'hC33C, 3'(VP-1), 1'b0, 4'd0, "R2");
        step(1'b0, '0, '0, '0, 1'b1, 4'd15, "R8");
        // R5: write and transfer on one edge, then a plain transfer
        step(1'b1, {4'd0, 4'd0}, 16'h1234, 3'd0, 1'b1, 4'd2, "R5");
        step(1'b0, '0, '0, '0, 1'b1, 4'd2, "R5");
        // R6: horizontal and vertical positions out of range
        step(1'b1, {4'(H), 4'd1}, 16'hDEAD, 3'd0, 1'b0, 4'd0, "R6");
        step(1'b1, {4'd15, 4'd2}, 16'hBEEF, 3'd1, 1'b0, 4'd0, "R6");
        step(1'b1, {4'd0, 4'd4}, 16'hF00D, 3'(VP), 1'b0, 4'd0, "R6");
        step(1'b1, {4'd1, 4'd5}, 16'h0BAD, 3'd7, 1'b0, 4'd0, "R6");
        step(1'b0, '0, '0, '0, 1'b1, 4'd7, "R6");
        // R7: strobe low with live address and data
        step(1'b0, {4'd0, 4'd0}, 16'h5555, 3'd0, 1'b0, 4'd0, "R7");
        step(1'b0, {4'd1, 4'd3}, 16'hAAAA, 3'd1, 1'b0, 4'd0, "R7");
        step(1'b0, '0, '0, '0, 1'b1, 4'd7, "R7");
        // R4: repeated transfer shows the same contents
        step(1'b0, '0, '0, '0, 1'b1, 4'd1, "R4");

        for (int i = 0; i < 500; i++) begin
            logic       wr, xf;
            logic [3:0] hh, kk, rc;
            logic [2:0] vs;
            wr = ($urandom % 4) != 0;
            xf = ($urandom % 5) == 0;
            hh = 4'($urandom % (H + 1));
            if (($urandom % 16) == 0) hh = 4'($urandom);
            kk = 4'($urandom);
            vs = 3'($urandom % (VP + 1));
            rc = 4'($urandom);
            step(wr, {hh, kk}, 16'($urandom), vs, xf, rc,
                 (wr && xf) ? "R5" : (xf ? "R4" : "R3"));
        end
        step(1'b0, '0, '0, '0, 1'b1, 4'd3, "R4");
        finish_run();
    end
endmodule